// File: doc/BRIEF.md
# Burst-Mode Step-Up Switch Timing Controller

This block produces the gate signal for the power switch of a step-up converter that regulates in bursts. A synchronous flag from the regulation comparator says whether the converter output has fallen below its target. While that flag is raised, the block runs a chain of switching cycles. Each cycle has a bounded on-pulse followed by an off-gap. When the flag drops, the block lets the running cycle finish and then parks the switch until the flag rises again.

A peak-current trip ends an on-pulse early. When that happens, the following off-gap is stretched so the inductor can empty. Two trip inputs come in, one for the full current threshold and one for the reduced threshold. A select line picks the one that counts. All inputs pass through synchronisers. Shutdown kills the outputs at once, without waiting for the clock, and returns the sequencer to idle. All durations are given in nanoseconds and converted to clock cycles from the clock frequency parameter.

Top module: `burst_switch_ctrl`

## Requirements
- R1: While reset is held, and right after it, `sw_drive_o` and `osc_run_o` are 0 and `phase_o` is 2'b00.
- R2: While `reg_low_i` is 0, no on-pulse starts. `sw_drive_o` stays 0 and `phase_o` stays 2'b00.
- R3: A rise of `reg_low_i` from idle raises `sw_drive_o` on the third rising clock edge after the input changes. Without a trip, the on-pulse lasts exactly TON cycles (1060 at the defaults).
- R4: A normal on-pulse is followed by exactly TOFF low cycles (240 at the defaults). If `reg_low_i` is still 1 at the end of that gap, the next on-pulse starts.
- R5: A selected trip that is raised during an on-pulse ends it on the third rising edge after the input changes. The off-gap that follows lasts exactly TOFFX cycles (400 at the defaults).
- R6: When the trip and the on-time expiry land on the same cycle, the trip wins and the off-gap is TOFFX cycles.
- R7: With `lim_sel_i` = 0, only `trip_hi_i` can end a pulse. With `lim_sel_i` = 1, only `trip_lo_i` can. The input that is not selected has no effect on pulse length.
- R8: If `reg_low_i` falls during an on-pulse, that pulse and its off-gap still complete in full. The block then goes idle and no further pulse starts.
- R9: `phase_o` encodes 2'b00 idle, 2'b01 on-pulse, 2'b10 normal off-gap and 2'b11 stretched off-gap. `osc_run_o` is 1 exactly when the phase is not idle.
- R10: `shdn_i` = 1 forces `sw_drive_o`, `osc_run_o` and `phase_o` to 0 without waiting for a clock edge, and sends the sequencer to idle. After release, with `reg_low_i` still 1, a new full on-pulse starts on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_low_i | input | 1 | 1 when the converter output is below target |
| trip_hi_i | input | 1 | Peak-current trip at the full threshold |
| trip_lo_i | input | 1 | Peak-current trip at the reduced threshold |
| lim_sel_i | input | 1 | Trip select: 0 full, 1 reduced |
| shdn_i | input | 1 | Shutdown, overrides everything |
| sw_drive_o | output | 1 | Power switch gate drive |
| osc_run_o | output | 1 | Cycle timer is running |
| phase_o | output | 2 | Current phase code |

## Verification
The bench measures every on-pulse and off-gap at the ports and compares each one with a queued expectation.

It checks a trip that lands on the last on-cycle. A design that lets the expiry win would show a 240-cycle gap instead of 400. It checks a regulation drop in the middle of a pulse. A design that stops at once would cut the pulse short, and one that ignores the drop would start another pulse. It also drives the unselected trip input, which a miswired select would let shorten the pulse. Finally, it checks shutdown in the middle of a pulse: the drive must drop within the same time step, and a full pulse must start afterwards, which a stale counter would break.

// File: rtl/bst_pkg.sv
package bst_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_ON   = 2'b01,
      PH_OFF  = 2'b10,
      PH_OFFX = 2'b11
   } phase_e;

   // Round a duration in nanoseconds to clock cycles.
   function automatic int ns_to_cyc(input int clk_mhz, input int dur_ns);
      return (clk_mhz * dur_ns + 500) / 1000;
   endfunction

endpackage

// File: rtl/bst_sync.sv
module bst_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      a_param_stages : assert (STAGES >= 2)
         else $error("bst_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bst_seq.sv
module bst_seq
   import bst_pkg::*;
#(
   parameter int TON_CYC   = 1060,
   parameter int TOFF_CYC  = 240,
   parameter int TOFFX_CYC = 400,
   parameter int CNT_W     = 11
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   halt,
   input  logic   run_req,
   input  logic   trip,
   output phase_e phase
);

   localparam logic [CNT_W-1:0] LD_ON   = CNT_W'(TON_CYC - 1);
   localparam logic [CNT_W-1:0] LD_OFF  = CNT_W'(TOFF_CYC - 1);
   localparam logic [CNT_W-1:0] LD_OFFX = CNT_W'(TOFFX_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (halt) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (run_req) begin
                  phase <= PH_ON;
                  cnt   <= LD_ON;
               end
            end
            PH_ON: begin
               if (trip) begin
                  phase <= PH_OFFX;
                  cnt   <= LD_OFFX;
               end else if (cnt == '0) begin
                  phase <= PH_OFF;
                  cnt   <= LD_OFF;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_OFF, PH_OFFX: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (run_req) begin
                  phase <= PH_ON;
                  cnt   <= LD_ON;
               end else begin
                  phase <= PH_IDLE;
               end
            end
         endcase
      end
   end

   // R5: a trip seen during an on-pulse leads to the stretched gap
   a_r5_trip_stretches : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ON && trip && !halt) |=> (phase == PH_OFFX));

   // R8: an on-pulse only begins when regulation still asks for one
   a_r8_start_needs_req : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase == PH_ON) |-> $past(run_req));

   // R4: an off-gap is never shorter than two cycles
   a_r4_gap_floor : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phase == PH_ON) |=> (phase != PH_ON));

endmodule

// File: rtl/burst_switch_ctrl.sv
module burst_switch_ctrl
   import bst_pkg::*;
#(
   parameter int CLK_MHZ     = 200,
   parameter int TON_NS      = 5300,
   parameter int TOFF_NS     = 1200,
   parameter int TOFFX_NS    = 2000,
   parameter int SYNC_STAGES = 2,
   parameter bit ASYNC_KILL  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_low_i,
   input  logic       trip_hi_i,
   input  logic       trip_lo_i,
   input  logic       lim_sel_i,
   input  logic       shdn_i,
   output logic       sw_drive_o,
   output logic       osc_run_o,
   output logic [1:0] phase_o
);

   localparam int TON_CYC   = ns_to_cyc(CLK_MHZ, TON_NS);
   localparam int TOFF_CYC  = ns_to_cyc(CLK_MHZ, TOFF_NS);
   localparam int TOFFX_CYC = ns_to_cyc(CLK_MHZ, TOFFX_NS);
   localparam int MAX_CYC   = (TON_CYC > TOFFX_CYC) ? TON_CYC : TOFFX_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);
   localparam int N_IN      = 5;

   initial begin
      a_param_on : assert (TON_CYC >= 1)
         else $error("on-time rounds to zero cycles");
      a_param_off : assert (TOFF_CYC >= 2)
         else $error("off-time must be at least two cycles");
      a_param_offx : assert (TOFFX_CYC >= TOFF_CYC)
         else $error("stretched off-time shorter than normal off-time");
   end

   logic [N_IN-1:0] raw_in, syn_in;
   logic            reg_low_s, trip_hi_s, trip_lo_s, lim_sel_s, shdn_s;
   logic            trip_sel, kill;
   phase_e          phase;

   assign raw_in = {shdn_i, lim_sel_i, trip_lo_i, trip_hi_i, reg_low_i};

   bst_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign {shdn_s, lim_sel_s, trip_lo_s, trip_hi_s, reg_low_s} = syn_in;

   // Current-limit select: 0 full threshold, 1 reduced threshold
   assign trip_sel = lim_sel_s ? trip_lo_s : trip_hi_s;

   bst_seq #(
      .TON_CYC   (TON_CYC),
      .TOFF_CYC  (TOFF_CYC),
      .TOFFX_CYC (TOFFX_CYC),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .halt    (shdn_s),
      .run_req (reg_low_s),
      .trip    (trip_sel),
      .phase   (phase)
   );

   generate
      if (ASYNC_KILL) begin : g_kill_async
         assign kill = shdn_i;
      end else begin : g_kill_sync
         assign kill = shdn_s;
      end
   endgenerate

   assign sw_drive_o = (phase == PH_ON) && !kill;
   assign osc_run_o  = (phase != PH_IDLE) && !kill;
   assign phase_o    = kill ? 2'b00 : phase;

   // R3: length of any on-pulse is bounded by the on-time
   logic [CNT_W:0] on_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              on_run <= '0;
      else if (phase == PH_ON) on_run <= on_run + 1'b1;
      else                     on_run <= '0;
   end

   a_r3_on_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      on_run <= (CNT_W+1)'(TON_CYC));

   // R9: drive only while the phase code reads on-pulse
   a_r9_drive_phase : assert property (@(posedge clk) disable iff (!rst_n)
      sw_drive_o |-> (phase_o == 2'b01 && osc_run_o));

   generate
      if (ASYNC_KILL) begin : g_kill_chk
         // R10: shutdown clears every output
         a_r10_shdn_quiet : assert property (@(posedge clk) disable iff (!rst_n)
            shdn_i |-> (!sw_drive_o && !osc_run_o && phase_o == 2'b00));
      end
   endgenerate

endmodule

// File: tb/burst_switch_ctrl_bench.sv
`timescale 1ns/1ps
module burst_switch_ctrl_bench;

   localparam int TON   = 1060;
   localparam int TOFF  = 240;
   localparam int TOFFX = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_low = 1'b0, trip_hi = 1'b0, trip_lo = 1'b0;
   logic       lim_sel = 1'b0, shdn = 1'b0;
   logic       sw_drive, osc_run;
   logic [1:0] phase;

   always #2.5 clk = ~clk;

   burst_switch_ctrl u_burst_switch_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_low_i  (reg_low),
      .trip_hi_i  (trip_hi),
      .trip_lo_i  (trip_lo),
      .lim_sel_i  (lim_sel),
      .shdn_i     (shdn),
      .sw_drive_o (sw_drive),
      .osc_run_o  (osc_run),
      .phase_o    (phase)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Scoreboard of expected pulse shapes
   typedef struct {
      int    on_len;
      int    off_len;   // -1: gap not checked (end of burst)
      string tag;
   } exp_t;
   exp_t sb_q[$];

   task automatic push_exp(input int on_len, input int off_len, input string tag);
      exp_t e;
      e.on_len = on_len; e.off_len = off_len; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic pop_cmp(input int on_len, input int off_len, input bit has_off);
      exp_t e;
      if (sb_q.size() == 0) begin
         check(1'b0, "R2", "unexpected pulse", on_len, 0);
         return;
      end
      e = sb_q.pop_front();
      check(on_len == e.on_len, e.tag, "on-pulse length", on_len, e.on_len);
      if (has_off && e.off_len >= 0)
         check(off_len == e.off_len, e.tag, "off-gap length", off_len, e.off_len);
   endtask

   // Monitor
   logic prev_d = 1'b0;
   int   run_len = 0, pend_on = 0, n_rise = 0, n_fall = 0;
   bit   have_pend = 0;

   always @(negedge clk) begin
      if (!rst_n || shdn) begin
         prev_d = 1'b0; run_len = 0; have_pend = 0;
      end else begin
         if (sw_drive != prev_d) begin
            if (sw_drive) begin
               n_rise++;
               if (have_pend) begin
                  pop_cmp(pend_on, run_len, 1'b1);
                  have_pend = 0;
               end
            end else begin
               n_fall++;
               pend_on = run_len;
               have_pend = 1;
            end
            run_len = 1;
         end else begin
            run_len++;
         end
         prev_d = sw_drive;
      end
   end

   task automatic flush();
      if (have_pend) begin
         pop_cmp(pend_on, 0, 1'b0);
         have_pend = 0;
      end
   endtask

   task automatic wait_idle(input string req);
      repeat (TOFFX + 10) @(negedge clk);
      check(phase == 2'b00 && !osc_run, req, "idle after burst", phase, 0);
      flush();
   endtask

   initial begin
      int base_r, base_f;

      // R1: reset state
      repeat (5) @(negedge clk);
      check(!sw_drive && !osc_run && phase == 2'b00, "R1", "outputs in reset",
            {sw_drive, osc_run, phase}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!sw_drive && !osc_run && phase == 2'b00, "R1", "outputs after reset",
            {sw_drive, osc_run, phase}, 0);

      // R2: regulated, nothing happens
      repeat (200) @(negedge clk);
      check(n_rise == 0 && phase == 2'b00, "R2", "rises while regulated", n_rise, 0);

      // R3 / R4 / R8 / R9: plain burst, stop in the middle of the 4th pulse
      push_exp(TON, TOFF, "R4");
      push_exp(TON, TOFF, "R4");
      push_exp(TON, TOFF, "R4");
      push_exp(TON, -1,   "R8");
      reg_low = 1'b1;
      repeat (2) @(negedge clk);
      check(sw_drive == 1'b0, "R3", "drive before latency", sw_drive, 0);
      @(negedge clk);
      check(sw_drive == 1'b1, "R3", "drive at third edge", sw_drive, 1);
      repeat (10) @(negedge clk);
      check(phase == 2'b01 && osc_run, "R9", "phase code on", phase, 1);
      wait (n_fall >= 1);
      repeat (10) @(negedge clk);
      check(phase == 2'b10 && osc_run, "R9", "phase code normal off", phase, 2);
      wait (n_rise >= 4);
      repeat (20) @(negedge clk);
      reg_low = 1'b0;
      wait (n_fall >= 4);
      repeat (TOFF - 1) @(negedge clk);
      check(phase == 2'b10, "R8", "gap completes", phase, 2);
      @(negedge clk);
      check(phase == 2'b00 && !osc_run, "R8", "idle after last gap", phase, 0);
      repeat (400) @(negedge clk);
      check(n_rise == 4, "R8", "no pulse after regulation", n_rise, 4);
      flush();

      // R5: full-threshold trip cuts the pulse, gap stretched
      lim_sel = 1'b0;
      base_r = n_rise; base_f = n_fall;
      push_exp(103, TOFFX, "R5");
      push_exp(TON, -1, "R5");
      reg_low = 1'b1;
      wait (n_rise >= base_r + 1);
      repeat (100) @(negedge clk);
      trip_hi = 1'b1;
      wait (n_fall >= base_f + 1);
      check(phase == 2'b11, "R9", "phase code stretched off", phase, 3);
      trip_hi = 1'b0;
      wait (n_rise >= base_r + 2);
      repeat (5) @(negedge clk);
      reg_low = 1'b0;
      wait (n_fall >= base_f + 2);
      wait_idle("R5");

      // R7: select decides which trip counts
      base_r = n_rise; base_f = n_fall;
      push_exp(TON, TOFF, "R7");
      push_exp(TON, TOFF, "R7");
      push_exp(53, TOFFX, "R7");
      push_exp(TON, -1, "R7");
      reg_low = 1'b1;
      wait (n_rise >= base_r + 1);
      repeat (50) @(negedge clk);
      trip_lo = 1'b1;
      wait (n_fall >= base_f + 1);
      trip_lo = 1'b0;
      lim_sel = 1'b1;
      wait (n_rise >= base_r + 2);
      repeat (50) @(negedge clk);
      trip_hi = 1'b1;
      wait (n_fall >= base_f + 2);
      trip_hi = 1'b0;
      wait (n_rise >= base_r + 3);
      repeat (50) @(negedge clk);
      trip_lo = 1'b1;
      wait (n_fall >= base_f + 3);
      trip_lo = 1'b0;
      wait (n_rise >= base_r + 4);
      repeat (5) @(negedge clk);
      reg_low = 1'b0;
      wait (n_fall >= base_f + 4);
      wait_idle("R7");
      lim_sel = 1'b0;
      repeat (10) @(negedge clk);

      // R6: trip on the last on-cycle
      base_r = n_rise; base_f = n_fall;
      push_exp(TON, TOFFX, "R6");
      push_exp(TON, -1, "R6");
      reg_low = 1'b1;
      wait (n_rise >= base_r + 1);
      repeat (TON - 3) @(negedge clk);
      trip_hi = 1'b1;
      wait (n_fall >= base_f + 1);
      check(phase == 2'b11, "R6", "trip wins over expiry", phase, 3);
      trip_hi = 1'b0;
      wait (n_rise >= base_r + 2);
      repeat (5) @(negedge clk);
      reg_low = 1'b0;
      wait (n_fall >= base_f + 2);
      wait_idle("R6");

      // R10: shutdown in the middle of a pulse
      base_r = n_rise; base_f = n_fall;
      reg_low = 1'b1;
      wait (n_rise >= base_r + 1);
      repeat (30) @(negedge clk);
      shdn = 1'b1;
      #0.5;
      check(!sw_drive && !osc_run && phase == 2'b00, "R10", "immediate kill",
            {sw_drive, osc_run, phase}, 0);
      repeat (50) @(negedge clk);
      check(!sw_drive && phase == 2'b00 && n_rise == base_r + 1, "R10",
            "held off in shutdown", n_rise, base_r + 1);
      push_exp(TON, -1, "R10");
      shdn = 1'b0;
      repeat (2) @(negedge clk);
      check(sw_drive == 1'b0, "R10", "drive before restart", sw_drive, 0);
      @(negedge clk);
      check(sw_drive == 1'b1, "R10", "restart at third edge", sw_drive, 1);
      repeat (30) @(negedge clk);
      reg_low = 1'b0;
      wait (n_fall >= base_f + 1);
      wait_idle("R10");

      check(sb_q.size() == 0, "R4", "scoreboard drained", sb_q.size(), 0);

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule